// File: doc/BRIEF.md
# Sector Hamming Code Generator and Checker

This block builds a single-error-correcting parity code over a flash sector while the sector's bytes stream past it, one byte per clock. Every set data bit is located by its bit address, which is the byte index followed by the three-bit position inside the byte. The upper half of the code folds together the addresses of all set bits. The lower half folds together their complements. Both halves are then inverted, so a fully erased sector (all bytes 0xFF) yields an all-ones code and matches the all-ones value an erased spare area holds.

A start pulse opens a sector and latches the mode. When the last byte of the sector has been accepted, the block presents the code in parallel for one cycle and then shifts it out byte by byte, least significant byte first. In check mode, the block also compares the new code with a stored code and reports one of four results: clean, a correctable data error, an error in the stored code alone, or uncorrectable. For a correctable data error it gives the byte index and the bit index to flip. Another agent applies the flip.

Top module: `hecc_sector_ecc`

## Requirements
- R1: After reset, `code_vld_o`, `ser_vld_o` and `res_vld_o` are low.
- R2: With A = {byte index, bit position} (BYTE_AW+3 bits), let H be the XOR of A over all set data bits and L be the XOR of ~A over them. `code_o` = ~{H, L}. It is valid, with `code_vld_o` high for exactly one cycle, in the cycle after the sector's last byte is accepted.
- R3: A sector of all 0xFF bytes or all 0x00 bytes produces an all-ones code.
- R4: `start_i` clears the accumulator and the byte count, discarding any partial sector. A byte offered in the same cycle as `start_i` is byte 0 of the new sector. After a complete sector the accumulator restarts from zero without a start pulse.
- R5: Cycles with `byte_vld_i` low change neither the code nor the byte count.
- R6: Starting the cycle after `code_vld_o`, the code appears on `ser_byte_o` over CODE_BYTES consecutive cycles with `ser_vld_o` high, least significant byte first, and the last byte is zero-padded.
- R7: `check_mode_i` is sampled only with `start_i`. Only in check mode does `res_vld_o` pulse, together with `code_vld_o`. `stored_code_i` is sampled in the cycle of the last byte. A zero difference (code XOR stored) gives result 0 (clean).
- R8: The result is 1 (data fix) when the upper half of the difference XOR its lower half is all ones and the byte index in the difference is below SECTOR_BYTES. In that case `fix_byte_o` = difference bits [CODE_W-1:AW+3] and `fix_bit_o` = difference bits [AW+2:AW].
- R9: A difference with exactly one bit set gives result 2 (stored code error, no data fix).
- R10: Every other nonzero difference gives result 3 (uncorrectable). This includes a complementary difference whose byte index is not below SECTOR_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Open a new sector, latch mode |
| check_mode_i | input | 1 | 1 = compare with stored code |
| byte_vld_i | input | 1 | Data byte valid |
| byte_i | input | 8 | Data byte |
| stored_code_i | input | CODE_W (24) | Code read back from the spare area |
| code_vld_o | output | 1 | One-cycle code valid pulse |
| code_o | output | CODE_W (24) | Computed code |
| ser_vld_o | output | 1 | Serial code byte valid |
| ser_byte_o | output | 8 | Serial code byte, LSB first |
| res_vld_o | output | 1 | Check result valid pulse |
| res_o | output | 2 | 0 clean, 1 data fix, 2 code error, 3 uncorrectable |
| fix_byte_o | output | BYTE_AW (9) | Byte index to flip |
| fix_bit_o | output | 3 | Bit index to flip |

## Verification
The bench builds one instance with SECTOR_BYTES = 6. This gives 48 data bits, a 12-bit code and a byte index field that can name bytes 6 and 7, which do not exist. That makes every single data-bit flip, every single code-bit flip and every out-of-range complementary difference cheap to sweep, and it also reaches the range test, which the default power-of-two size removes. A second instance at the default 512 bytes covers the full 24-bit packing, the three-byte serial order, the erased sector and flips near both ends of a real sector.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
   typedef enum logic [1:0] {
      HECC_CLEAN    = 2'd0,
      HECC_DATA_FIX = 2'd1,
      HECC_CODE_ERR = 2'd2,
      HECC_UNCORR   = 2'd3
   } hecc_res_e;

   localparam int HECC_LANES   = 8;
   localparam int HECC_LANE_AW = 3;
endpackage

// File: rtl/hecc_accum.sv
module hecc_accum
   import hecc_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int BYTE_AW      = 9,
   parameter int AW           = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  vld_i,
   input  logic [HECC_LANES-1:0] byte_i,
   output logic                  last_o,
   output logic [AW-1:0]         nxt_hi_o,
   output logic [AW-1:0]         nxt_lo_o
);
   logic [BYTE_AW-1:0] cnt_q, base_cnt;
   logic [AW-1:0]      hi_q, lo_q, base_hi, base_lo, add_hi, add_lo;
   logic [AW-1:0]      lane_addr [HECC_LANES];

   // a start pulse discards whatever the sector held so far
   assign base_cnt = start_i ? '0 : cnt_q;
   assign base_hi  = start_i ? '0 : hi_q;
   assign base_lo  = start_i ? '0 : lo_q;

   for (genvar g = 0; g < HECC_LANES; g++) begin : g_lane
      assign lane_addr[g] = {base_cnt, HECC_LANE_AW'(g)};
   end

   always_comb begin
      add_hi = '0;
      add_lo = '0;
      for (int l = 0; l < HECC_LANES; l++) begin
         if (byte_i[l]) begin
            add_hi = add_hi ^ lane_addr[l];
            add_lo = add_lo ^ ~lane_addr[l];
         end
      end
   end

   assign last_o   = vld_i && (base_cnt == BYTE_AW'(SECTOR_BYTES - 1));
   assign nxt_hi_o = base_hi ^ add_hi;
   assign nxt_lo_o = base_lo ^ add_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hi_q  <= '0;
         lo_q  <= '0;
      end else if (vld_i) begin
         if (last_o) begin
            cnt_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
         end else begin
            cnt_q <= base_cnt + 1'b1;
            hi_q  <= nxt_hi_o;
            lo_q  <= nxt_lo_o;
         end
      end else if (start_i) begin
         cnt_q <= '0;
         hi_q  <= '0;
         lo_q  <= '0;
      end
   end
endmodule

// File: rtl/hecc_eval.sv
module hecc_eval
   import hecc_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int BYTE_AW      = 9,
   parameter int AW           = 12,
   parameter int CODE_W       = 24
) (
   input  logic [CODE_W-1:0]       calc_i,
   input  logic [CODE_W-1:0]       stored_i,
   output hecc_res_e               res_o,
   output logic [BYTE_AW-1:0]      fix_byte_o,
   output logic [HECC_LANE_AW-1:0] fix_bit_o
);
   logic [CODE_W-1:0] diff;
   logic [AW-1:0]     dhi, dlo;
   logic              in_range;

   assign diff       = calc_i ^ stored_i;
   assign dhi        = diff[CODE_W-1:AW];
   assign dlo        = diff[AW-1:0];
   assign fix_byte_o = dhi[AW-1:HECC_LANE_AW];
   assign fix_bit_o  = dhi[HECC_LANE_AW-1:0];

   // a power-of-two sector cannot name a byte past its end
   if ((1 << BYTE_AW) == SECTOR_BYTES) begin : g_pow2
      assign in_range = 1'b1;
   end else begin : g_range
      assign in_range = ({1'b0, fix_byte_o} < (BYTE_AW + 1)'(SECTOR_BYTES));
   end

   always_comb begin
      if (diff == '0)
         res_o = HECC_CLEAN;
      else if ((dhi ^ dlo) == '1)
         res_o = in_range ? HECC_DATA_FIX : HECC_UNCORR;
      else if ($onehot(diff))
         res_o = HECC_CODE_ERR;
      else
         res_o = HECC_UNCORR;
   end
endmodule

// File: rtl/hecc_serial.sv
module hecc_serial #(
   parameter int CODE_W     = 24,
   parameter int CODE_BYTES = 3,
   localparam int WIDE_W    = CODE_BYTES * 8,
   localparam int PAD_W     = WIDE_W - CODE_W,
   localparam int CNT_W     = $clog2(CODE_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              vld_o,
   output logic [7:0]        byte_o
);
   logic [WIDE_W-1:0] wide, buf_q;
   logic [CNT_W-1:0]  cnt_q;

   if (PAD_W == 0) begin : g_nopad
      assign wide = code_i;
   end else begin : g_pad
      assign wide = {{PAD_W{1'b0}}, code_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         buf_q <= wide;
         cnt_q <= CNT_W'(CODE_BYTES);
      end else if (cnt_q != '0) begin
         buf_q <= buf_q >> 8;
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign vld_o  = (cnt_q != '0);
   assign byte_o = buf_q[7:0];
endmodule

// File: rtl/hecc_sector_ecc.sv
module hecc_sector_ecc
   import hecc_pkg::*;
#(
   parameter int  SECTOR_BYTES = 512,
   localparam int BYTE_AW      = $clog2(SECTOR_BYTES),
   localparam int AW           = BYTE_AW + HECC_LANE_AW,
   localparam int CODE_W       = 2 * AW,
   localparam int CODE_BYTES   = (CODE_W + 7) / 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    check_mode_i,
   input  logic                    byte_vld_i,
   input  logic [7:0]              byte_i,
   input  logic [CODE_W-1:0]       stored_code_i,
   output logic                    code_vld_o,
   output logic [CODE_W-1:0]       code_o,
   output logic                    ser_vld_o,
   output logic [7:0]              ser_byte_o,
   output logic                    res_vld_o,
   output logic [1:0]              res_o,
   output logic [BYTE_AW-1:0]      fix_byte_o,
   output logic [HECC_LANE_AW-1:0] fix_bit_o
);
   if (SECTOR_BYTES < CODE_BYTES) begin : g_bad_size
      $error("SECTOR_BYTES must cover the serial code length");
   end
   if (SECTOR_BYTES < 2) begin : g_bad_min
      $error("SECTOR_BYTES must be at least 2");
   end

   logic              last;
   logic [AW-1:0]     nxt_hi, nxt_lo;
   logic [CODE_W-1:0] calc_code;
   hecc_res_e         res_c;
   logic [BYTE_AW-1:0]      fb_c;
   logic [HECC_LANE_AW-1:0] fbit_c;

   logic                    mode_q, code_vld_q, res_vld_q;
   logic [CODE_W-1:0]       code_q;
   hecc_res_e               res_q;
   logic [BYTE_AW-1:0]      fb_q;
   logic [HECC_LANE_AW-1:0] fbit_q;

   hecc_accum #(.SECTOR_BYTES(SECTOR_BYTES), .BYTE_AW(BYTE_AW), .AW(AW)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .vld_i    (byte_vld_i),
      .byte_i   (byte_i),
      .last_o   (last),
      .nxt_hi_o (nxt_hi),
      .nxt_lo_o (nxt_lo)
   );

   // inverted packing: erased flash reads back as a matching code
   assign calc_code = ~{nxt_hi, nxt_lo};

   hecc_eval #(.SECTOR_BYTES(SECTOR_BYTES), .BYTE_AW(BYTE_AW), .AW(AW), .CODE_W(CODE_W)) u_eval (
      .calc_i     (calc_code),
      .stored_i   (stored_code_i),
      .res_o      (res_c),
      .fix_byte_o (fb_c),
      .fix_bit_o  (fbit_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q     <= 1'b0;
         code_vld_q <= 1'b0;
         res_vld_q  <= 1'b0;
         code_q     <= '0;
         res_q      <= HECC_CLEAN;
         fb_q       <= '0;
         fbit_q     <= '0;
      end else begin
         if (start_i) mode_q <= check_mode_i;
         code_vld_q <= last;
         res_vld_q  <= last && mode_q;
         if (last) code_q <= calc_code;
         if (last && mode_q) begin
            res_q  <= res_c;
            fb_q   <= fb_c;
            fbit_q <= fbit_c;
         end
      end
   end

   hecc_serial #(.CODE_W(CODE_W), .CODE_BYTES(CODE_BYTES)) u_serial (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (code_vld_q),
      .code_i (code_q),
      .vld_o  (ser_vld_o),
      .byte_o (ser_byte_o)
   );

   assign code_vld_o = code_vld_q;
   assign code_o     = code_q;
   assign res_vld_o  = res_vld_q;
   assign res_o      = res_q;
   assign fix_byte_o = fb_q;
   assign fix_bit_o  = fbit_q;
endmodule

// File: rtl/hecc_sector_ecc_chk.sv
module hecc_sector_ecc_chk #(
   parameter int  SECTOR_BYTES = 512,
   localparam int BYTE_AW      = $clog2(SECTOR_BYTES),
   localparam int CODE_W       = 2 * (BYTE_AW + 3)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CODE_W-1:0]  stored_code_i,
   input logic               code_vld_o,
   input logic [CODE_W-1:0]  code_o,
   input logic               ser_vld_o,
   input logic [7:0]         ser_byte_o,
   input logic               res_vld_o,
   input logic [1:0]         res_o,
   input logic [BYTE_AW-1:0] fix_byte_o
);
   assert_code_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      code_vld_o |=> !code_vld_o);

   assert_serial_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      code_vld_o |=> (ser_vld_o && ser_byte_o == $past(code_o[7:0])));

   assert_res_with_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_o |-> code_vld_o);

   assert_clean_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld_o && res_o == 2'd0) |-> (code_o == $past(stored_code_i)));

   assert_fix_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld_o && res_o == 2'd1) |-> ({1'b0, fix_byte_o} < (BYTE_AW + 1)'(SECTOR_BYTES)));

   assert_code_err_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld_o && res_o == 2'd2) |-> $onehot(code_o ^ $past(stored_code_i)));
endmodule

bind hecc_sector_ecc hecc_sector_ecc_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .stored_code_i (stored_code_i),
   .code_vld_o    (code_vld_o),
   .code_o        (code_o),
   .ser_vld_o     (ser_vld_o),
   .ser_byte_o    (ser_byte_o),
   .res_vld_o     (res_vld_o),
   .res_o         (res_o),
   .fix_byte_o    (fix_byte_o)
);

// File: tb/hecc_sector_ecc_test.sv
`timescale 1ns/1ps
module hecc_sector_ecc_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // small instance: 6 bytes, 12-bit code
   logic        s_start = 0, s_mode = 0, s_vld = 0;
   logic [7:0]  s_byte = 0;
   logic [11:0] s_stored = 0;
   logic        s_cv, s_sv, s_rv;
   logic [11:0] s_code;
   logic [7:0]  s_ser;
   logic [1:0]  s_res;
   logic [2:0]  s_fb, s_fbit;

   hecc_sector_ecc #(.SECTOR_BYTES(6)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(s_start), .check_mode_i(s_mode),
      .byte_vld_i(s_vld), .byte_i(s_byte), .stored_code_i(s_stored),
      .code_vld_o(s_cv), .code_o(s_code), .ser_vld_o(s_sv), .ser_byte_o(s_ser),
      .res_vld_o(s_rv), .res_o(s_res), .fix_byte_o(s_fb), .fix_bit_o(s_fbit));

   // default instance: 512 bytes, 24-bit code
   logic        b_start = 0, b_mode = 0, b_vld = 0;
   logic [7:0]  b_byte = 0;
   logic [23:0] b_stored = 0;
   logic        b_cv, b_sv, b_rv;
   logic [23:0] b_code;
   logic [7:0]  b_ser;
   logic [1:0]  b_res;
   logic [8:0]  b_fb;
   logic [2:0]  b_fbit;

   hecc_sector_ecc uut_big (
      .clk(clk), .rst_n(rst_n), .start_i(b_start), .check_mode_i(b_mode),
      .byte_vld_i(b_vld), .byte_i(b_byte), .stored_code_i(b_stored),
      .code_vld_o(b_cv), .code_o(b_code), .ser_vld_o(b_sv), .ser_byte_o(b_ser),
      .res_vld_o(b_rv), .res_o(b_res), .fix_byte_o(b_fb), .fix_bit_o(b_fbit));

   logic [7:0] sdat [6];
   logic [7:0] bdat [512];

   // captured outputs of the last sector
   logic        c_cv, c_rv, c_sv0, c_sv1, c_sv2, c_sv3;
   logic [23:0] c_code;
   logic [1:0]  c_res;
   logic [8:0]  c_fb;
   logic [2:0]  c_fbit;
   logic [7:0]  c_ser0, c_ser1, c_ser2;

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] sref();
      logic [5:0] h = '0, l = '0;
      for (int b = 0; b < 6; b++)
         for (int i = 0; i < 8; i++)
            if (sdat[b][i]) begin
               h ^= 6'(b * 8 + i);
               l ^= ~6'(b * 8 + i);
            end
      return ~{h, l};
   endfunction

   function automatic logic [23:0] bref();
      logic [11:0] h = '0, l = '0;
      for (int b = 0; b < 512; b++)
         for (int i = 0; i < 8; i++)
            if (bdat[b][i]) begin
               h ^= 12'(b * 8 + i);
               l ^= ~12'(b * 8 + i);
            end
      return ~{h, l};
   endfunction

   // how: 0 separate start cycle, 1 start with first byte, 2 no start
   task automatic run_small(input bit chkm, input logic [11:0] stored, input int gap, input int how);
      @(negedge clk);
      s_stored = stored;
      if (how == 0) begin
         s_start = 1; s_mode = chkm; s_vld = 0;
         @(negedge clk);
         s_start = 0; s_mode = ~chkm;
      end
      for (int b = 0; b < 6; b++) begin
         s_vld = 1; s_byte = sdat[b];
         if (how == 1 && b == 0) begin s_start = 1; s_mode = chkm; end
         @(negedge clk);
         s_start = 0;
         if (how == 1) s_mode = ~chkm;
         if (gap > 0 && b < 5) begin
            s_vld = 0;
            repeat (gap) @(negedge clk);
         end
      end
      s_vld = 0;
      c_cv = s_cv; c_code = 24'(s_code); c_rv = s_rv; c_res = s_res;
      c_fb = 9'(s_fb); c_fbit = s_fbit;
      @(negedge clk); c_sv0 = s_sv; c_ser0 = s_ser;
      @(negedge clk); c_sv1 = s_sv; c_ser1 = s_ser;
      @(negedge clk); c_sv2 = s_sv;
   endtask

   task automatic run_big(input bit chkm, input logic [23:0] stored);
      @(negedge clk);
      b_stored = stored; b_start = 1; b_mode = chkm;
      @(negedge clk);
      b_start = 0;
      for (int b = 0; b < 512; b++) begin
         b_vld = 1; b_byte = bdat[b];
         @(negedge clk);
      end
      b_vld = 0;
      c_cv = b_cv; c_code = b_code; c_rv = b_rv; c_res = b_res;
      c_fb = b_fb; c_fbit = b_fbit;
      @(negedge clk); c_sv0 = b_sv; c_ser0 = b_ser;
      @(negedge clk); c_sv1 = b_sv; c_ser1 = b_ser;
      @(negedge clk); c_sv2 = b_sv; c_ser2 = b_ser;
      @(negedge clk); c_sv3 = b_sv;
   endtask

   task automatic fill_small(input int seed);
      for (int b = 0; b < 6; b++) sdat[b] = 8'((b * 53 + seed * 29 + 7) ^ (seed << b));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [11:0] ref_s;
      logic [23:0] ref_b;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 code_vld", s_cv, 0);
      chk("R1 ser_vld", s_sv, 0);
      chk("R1 res_vld", s_rv, 0);
      chk("R1 big code_vld", b_cv, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R2/R6/R7 encode mode on several patterns
      for (int p = 0; p < 4; p++) begin
         fill_small(p);
         ref_s = sref();
         run_small(0, 12'h000, 0, 0);
         chk("R2 code_vld", c_cv, 1);
         chk("R2 code", c_code, ref_s);
         chk("R7 no result in encode mode", c_rv, 0);
         chk("R6 ser byte0", {c_sv0, c_ser0}, {1'b1, ref_s[7:0]});
         chk("R6 ser byte1", {c_sv1, c_ser1}, {1'b1, 4'h0, ref_s[11:8]});
         chk("R6 ser ends", c_sv2, 0);
      end

      // R3 erased and blank sectors
      for (int b = 0; b < 6; b++) sdat[b] = 8'hFF;
      run_small(0, 0, 0, 0);
      chk("R3 erased small", c_code, 12'hFFF);
      for (int b = 0; b < 6; b++) sdat[b] = 8'h00;
      run_small(0, 0, 0, 0);
      chk("R3 blank small", c_code, 12'hFFF);

      // R5 idle gaps
      fill_small(7);
      ref_s = sref();
      run_small(0, 0, 3, 0);
      chk("R5 gaps", c_code, ref_s);

      // R4 start discards a partial sector
      @(negedge clk);
      s_start = 1; s_mode = 0;
      @(negedge clk);
      s_start = 0;
      for (int b = 0; b < 3; b++) begin
         s_vld = 1; s_byte = 8'hA5 + 8'(b);
         @(negedge clk);
      end
      s_vld = 0;
      run_small(0, 0, 0, 0);
      chk("R4 restart after partial", c_code, ref_s);
      // R4 partial then start together with first byte
      @(negedge clk);
      for (int b = 0; b < 2; b++) begin
         s_vld = 1; s_byte = 8'h3C;
         @(negedge clk);
      end
      s_vld = 0;
      run_small(1, ref_s, 0, 1);
      chk("R4 start with byte0", c_code, ref_s);
      chk("R7 latched mode", c_rv, 1);
      chk("R7 clean", c_res, 0);
      // R4 back to back without start keeps check mode
      run_small(1, ref_s, 0, 2);
      chk("R4 no-start sector", c_code, ref_s);
      chk("R7 clean again", {c_rv, c_res}, {1'b1, 2'd0});

      // R8 every single data bit
      fill_small(11);
      ref_s = sref();
      for (int b = 0; b < 6; b++)
         for (int i = 0; i < 8; i++) begin
            sdat[b][i] = ~sdat[b][i];
            run_small(1, ref_s, 0, 0);
            sdat[b][i] = ~sdat[b][i];
            chk("R8 data fix", {c_rv, c_res, c_fb[2:0], c_fbit},
                {1'b1, 2'd1, 3'(b), 3'(i)});
         end

      // R9 every single stored code bit
      for (int k = 0; k < 12; k++) begin
         run_small(1, ref_s ^ (12'h1 << k), 0, 0);
         chk("R9 code only", {c_rv, c_res}, {1'b1, 2'd2});
      end

      // R10 complementary difference past the sector end
      for (int a = 48; a < 64; a++) begin
         run_small(1, ref_s ^ {6'(a), ~6'(a)}, 0, 0);
         chk("R10 byte out of range", {c_rv, c_res}, {1'b1, 2'd3});
      end
      // R10 double data flips
      for (int k = 0; k < 5; k++) begin
         sdat[k][k] = ~sdat[k][k];
         sdat[5][7 - k] = ~sdat[5][7 - k];
         run_small(1, ref_s, 0, 0);
         sdat[k][k] = ~sdat[k][k];
         sdat[5][7 - k] = ~sdat[5][7 - k];
         chk("R10 double error", {c_rv, c_res}, {1'b1, 2'd3});
      end

      // full-size instance
      for (int b = 0; b < 512; b++) bdat[b] = 8'hFF;
      run_big(1, 24'hFFFFFF);
      chk("R3 erased big", c_code, 24'hFFFFFF);
      chk("R7 erased big clean", {c_rv, c_res}, {1'b1, 2'd0});
      for (int b = 0; b < 512; b++) bdat[b] = 8'((b * 37 + 5) ^ (b >> 3));
      ref_b = bref();
      run_big(0, 0);
      chk("R2 big code", c_code, ref_b);
      chk("R6 big ser0", {c_sv0, c_ser0}, {1'b1, ref_b[7:0]});
      chk("R6 big ser1", {c_sv1, c_ser1}, {1'b1, ref_b[15:8]});
      chk("R6 big ser2", {c_sv2, c_ser2}, {1'b1, ref_b[23:16]});
      chk("R6 big ends", c_sv3, 0);
      bdat[300][5] = ~bdat[300][5];
      run_big(1, ref_b);
      bdat[300][5] = ~bdat[300][5];
      chk("R8 big fix", {c_res, c_fb, c_fbit}, {2'd1, 9'd300, 3'd5});
      bdat[511][7] = ~bdat[511][7];
      run_big(1, ref_b);
      bdat[511][7] = ~bdat[511][7];
      chk("R8 big last bit", {c_res, c_fb, c_fbit}, {2'd1, 9'd511, 3'd7});
      bdat[0][0] = ~bdat[0][0];
      run_big(1, ref_b);
      bdat[0][0] = ~bdat[0][0];
      chk("R8 big first bit", {c_res, c_fb, c_fbit}, {2'd1, 9'd0, 3'd0});
      run_big(1, ref_b ^ 24'h800000);
      chk("R9 big code bit", c_res, 2'd2);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule